// File: doc/BRIEF.md
# Two-Bit Unsigned Divider with Zero-Divisor Flag

This block divides one small unsigned operand by another in pure combinational logic. It returns the integer quotient, rounded down, and the remainder. A separate flag is raised when the divisor is zero. While that flag is high, the quotient and remainder carry no meaning, and the block forces both to zero so that downstream logic always sees a defined value.

The operands have no handshake, because the block holds no state and has no latency. A consumer reads the results in the same cycle in which it presents the operands.

Internally, a chain of restoring subtract stages produces one quotient bit per operand bit, starting from the most significant. The operand width is a parameter whose default is 2.

Top module: `div_unit`

## Requirements
- R1: For every nonzero divisor `b_opnd`, `quot` equals `a_opnd / b_opnd` rounded toward zero, as an unsigned value.
- R2: For every nonzero divisor, `rem` equals `a_opnd` modulo `b_opnd`.
- R3: For every nonzero divisor, `rem < b_opnd` and `quot * b_opnd + rem == a_opnd`.
- R4: `div_err` is 1 exactly when `b_opnd` is 0, and 0 otherwise.
- R5: When `b_opnd` is 0, both `quot` and `rem` are 0 for every value of `a_opnd`.
- R6: The outputs depend only on the present operands. A change of operands shows on the outputs in the same cycle, with no clock edge in between, and earlier operand values have no effect.
- R7: When `a_opnd < b_opnd`, `quot` is 0 and `rem` equals `a_opnd`.
- R8: When `b_opnd` is 1, `quot` equals `a_opnd` and `rem` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_opnd | input | DIV_W (2) | Unsigned dividend |
| b_opnd | input | DIV_W (2) | Unsigned divisor |
| quot | output | DIV_W (2) | Quotient; 0 when the divisor is zero |
| rem | output | DIV_W (2) | Remainder; 0 when the divisor is zero |
| div_err | output | 1 | High when the divisor is zero |

## Verification
The block has no stored state. A faulty stage therefore shows at the ports in the same evaluation as the operands that exercise it, with no delay. A wrong trial subtraction in one stage breaks the quotient bit of that stage and also every later remainder. This is visible as a failure of the recomposition identity for that operand pair. A broken zero guard shows as a raised flag on a nonzero divisor, or as nonzero results on a zero divisor. Stimulus that changes the operands between clock edges shows any output that follows stale operands.

// File: rtl/div_pkg.sv
package div_pkg;
  // Default operand width for the divider
  localparam int unsigned DIV_W_DEF = 2;

  // Reference floor division used by the in-RTL checks
  function automatic logic [63:0] ref_quot(input logic [31:0] a, input logic [31:0] b);
    return (b == 0) ? 64'd0 : 64'(a / b);
  endfunction
endpackage

// File: rtl/div_step.sv
module div_step #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] part_in,
  input  logic         next_bit,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] part_out,
  output logic         q_bit
);
  localparam int unsigned TW = W + 1;

  logic [TW-1:0] trial;
  logic [TW:0]   diff;

  always_comb begin
    trial    = {part_in, next_bit};
    diff     = {1'b0, trial} - {2'b00, divisor};
    q_bit    = ~diff[TW];
    part_out = q_bit ? diff[W-1:0] : trial[W-1:0];
  end

  always_comb begin
    if (!$isunknown({part_in, next_bit, divisor}) && divisor != '0 && part_in < divisor)
      AST_STEP_BOUND: assert (part_out < divisor) else $error("partial remainder out of range"); // R3
  end
endmodule

// File: rtl/div_zero_guard.sv
module div_zero_guard #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] divisor,
  input  logic [W-1:0] raw_q,
  input  logic [W-1:0] raw_r,
  output logic [W-1:0] q_out,
  output logic [W-1:0] r_out,
  output logic         zero_div
);
  always_comb begin
    zero_div = ~|divisor;
    q_out    = zero_div ? '0 : raw_q;
    r_out    = zero_div ? '0 : raw_r;
  end

  always_comb begin
    if (!$isunknown(divisor) && divisor == '0)
      AST_ZERO_MASK: assert (q_out == '0 && r_out == '0) else $error("results not masked"); // R5
  end
endmodule

// File: rtl/div_unit.sv
module div_unit #(
  parameter int unsigned DIV_W = div_pkg::DIV_W_DEF
) (
  input  logic [DIV_W-1:0] a_opnd,
  input  logic [DIV_W-1:0] b_opnd,
  output logic [DIV_W-1:0] quot,
  output logic [DIV_W-1:0] rem,
  output logic             div_err
);
  localparam int unsigned PW = 2 * DIV_W;

  // part[k] is the partial remainder entering stage k (k=0 uses MSB of a)
  logic [DIV_W:0][DIV_W-1:0] part;
  logic [DIV_W-1:0]          raw_q;

  assign part[0] = '0;

  for (genvar k = 0; k < DIV_W; k++) begin : g_stage
    div_step #(.W(DIV_W)) u_step (
      .part_in (part[k]),
      .next_bit(a_opnd[DIV_W-1-k]),
      .divisor (b_opnd),
      .part_out(part[k+1]),
      .q_bit   (raw_q[DIV_W-1-k])
    );
  end

  div_zero_guard #(.W(DIV_W)) u_guard (
    .divisor (b_opnd),
    .raw_q   (raw_q),
    .raw_r   (part[DIV_W]),
    .q_out   (quot),
    .r_out   (rem),
    .zero_div(div_err)
  );

  logic [PW-1:0] recomposed;
  always_comb begin
    recomposed = PW'(quot) * PW'(b_opnd) + PW'(rem);
    if (!$isunknown({a_opnd, b_opnd})) begin
      AST_ERR_FLAG: assert (div_err == (b_opnd == '0)) else $error("flag mismatch"); // R4
      if (b_opnd != '0) begin
        AST_REM_BELOW: assert (rem < b_opnd) else $error("remainder too large"); // R3
        AST_RECOMPOSE: assert (recomposed == PW'(a_opnd)) else $error("identity broken"); // R3
        AST_QUOT_REF: assert (64'(quot) == div_pkg::ref_quot(32'(a_opnd), 32'(b_opnd)))
          else $error("quotient wrong"); // R1
      end
    end
  end
endmodule

// File: tb/div_unit_tb.sv
module div_unit_tb;
  localparam int unsigned W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_opnd = '0, b_opnd = '0;
  logic [W-1:0] quot, rem;
  logic div_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  div_unit #(.DIV_W(W)) u_dut (
    .a_opnd(a_opnd), .b_opnd(b_opnd),
    .quot(quot), .rem(rem), .div_err(div_err)
  );

  function automatic int exp_q(int a, int b);
    return (b == 0) ? 0 : a / b;
  endfunction
  function automatic int exp_r(int a, int b);
    return (b == 0) ? 0 : a % b;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a_opnd, b_opnd, act, exp);
    end
  endtask

  task automatic apply(int a, int b);
    @(negedge clk);
    a_opnd = W'(a); b_opnd = W'(b);
    #2;
    chk("R1 quotient", int'(quot), exp_q(a, b));
    chk("R2 remainder", int'(rem), exp_r(a, b));
    chk("R4 flag", int'(div_err), (b == 0) ? 1 : 0);
    if (b != 0) begin
      chk("R3 identity", int'(quot) * b + int'(rem), a);
      chk("R3 bound", (int'(rem) < b) ? 1 : 0, 1);
    end else begin
      chk("R5 masked", int'(quot) + int'(rem), 0);
    end
    if (a < b) chk("R7 small dividend", int'(quot) * 8 + int'(rem), a);
    if (b == 1) chk("R8 unit divisor", int'(quot) * 8 + int'(rem), a * 8);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1;
    chk("R4 reset state flag", int'(div_err), 1);
    chk("R5 reset state outputs", int'(quot) + int'(rem), 0);
    rst_n = 1'b1;
    // Exhaustive directed sweep
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        apply(a, b);
    // R6: operands change twice between clock edges, outputs follow at once
    @(negedge clk);
    a_opnd = 2'd3; b_opnd = 2'd2; #1;
    chk("R6 first", int'(quot) * 8 + int'(rem), 9);
    a_opnd = 2'd2; b_opnd = 2'd3; #1;
    chk("R6 second no history", int'(quot) * 8 + int'(rem), 2);
    b_opnd = 2'd0; #1;
    chk("R6 zero divisor", int'(div_err), 1);
    // Random pairs
    for (int i = 0; i < 60; i++)
      apply(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule